// File: doc/BRIEF.md
# Stretchable Inter-Packet Gap Timer

This block sits beside a frame transmitter and decides when the next frame may start. When the transmitter finishes a frame, it pulses an end-of-frame strobe and presents the length of that frame in bit times, counting the preamble. The timer drops its ready output and counts bit-time ticks. It raises ready again once the required gap has passed.

The gap is 96 bit times by default. When stretching is enabled, the gap grows in proportion to the previous frame: the length is multiplied by an 8-bit factor and divided by an 8-bit divisor field plus one. The result is floored at 96 bit times. The product and quotient are formed over several clock cycles by a shift-add multiplier and a restoring shift-subtract divider. That work always finishes before the 96-bit minimum could expire, even with a tick on every clock. The enable, factor, divisor and length are sampled only on the end-of-frame strobe.

Top module: `ipg_timer`

## Requirements
- R1: After reset, txReady is high and stays high while no frameEnd pulse arrives, whatever bitTick does.
- R2: A frameEnd pulse sampled at a clock edge makes txReady low from that edge on.
- R3: With stretchEn low at the frameEnd edge, txReady rises right after the edge that samples the 96th bitTick following that frameEnd edge. A tick on the same edge as frameEnd is not counted.
- R4: With stretchEn high at the frameEnd edge, the gap in ticks is floor(frameLen * stretchMul / (stretchDiv + 1)). frameLen is in bit times including preamble. A stretchDiv of 0 divides by one.
- R5: A stretched gap that would come out below 96 ticks, including a stretchMul of 0, is held at 96 ticks.
- R6: frameLen, stretchEn, stretchMul and stretchDiv are sampled only on the frameEnd edge. Changes to them during a gap do not alter that gap.
- R7: A frameEnd pulse that arrives while a gap is running restarts the count from zero, using the values sampled at the new pulse.
- R8: The stretched gap is exact even when bitTick is high on every clock cycle. The sequential computation ends no more than MUL_W + PROD_W + 2 cycles after frameEnd.
- R9: Ticks received while txReady is high are not stored. A later frameEnd still waits the full gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameEnd | input | 1 | One-cycle pulse at the end of a transmitted frame |
| frameLen | input | LEN_W (16) | Length of that frame in bit times, preamble included |
| stretchEn | input | 1 | Enables length-proportional stretching |
| stretchMul | input | FIELD_W (8) | Stretch multiplier |
| stretchDiv | input | FIELD_W (8) | Stretch divisor minus one |
| bitTick | input | 1 | One pulse per bit time |
| txReady | output | 1 | High when the next frame may start |

## Verification
txReady falls one edge after the frameEnd edge and rises one edge after the tick that completes the gap. The bench therefore drives inputs on falling edges and counts ticks on rising edges, starting from zero at each frameEnd. It compares the count at the falling edge where txReady is first seen high against a gap value queued by the driver and computed from R3 to R5. The drop is checked at the falling edge that follows the strobe. Tick spacings of one and three cycles show that the result does not depend on tick density, and the one-cycle spacing also covers the compute-latency bound.

// File: rtl/ipg_timer_pkg.sv
package ipg_timer_pkg;

  typedef enum logic [2:0] {
    ST_READY,
    ST_MUL,
    ST_DINIT,
    ST_DIV,
    ST_FIN,
    ST_HOLD
  } gapState_t;

  typedef struct packed {
    logic load;
    logic mulStep;
    logic divInit;
    logic divStep;
    logic setTarget;
    logic cntRun;
  } gapStrobes_t;

endpackage

// File: rtl/ipg_timer_dp.sv
module ipg_timer_dp
  import ipg_timer_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int FIELD_W = 8,
  parameter int MIN_GAP = 96
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gapStrobes_t          strb,
  input  logic [LEN_W-1:0]     frameLen,
  input  logic [FIELD_W-1:0]   stretchMul,
  input  logic [FIELD_W-1:0]   stretchDiv,
  input  logic                 bitTick,
  output logic                 reachNow,
  output logic                 reachNext
);

  localparam int PROD_W = LEN_W + FIELD_W;
  localparam int DIV_W  = FIELD_W + 1;
  localparam logic [PROD_W-1:0] MIN_V = PROD_W'(MIN_GAP);
  localparam logic [PROD_W-1:0] CNT_MAX = {PROD_W{1'b1}};

  logic [FIELD_W-1:0] mulR;
  logic [DIV_W-1:0]   divR;
  logic [PROD_W-1:0]  addend;
  logic [PROD_W-1:0]  acc;
  logic [PROD_W-1:0]  quo;
  logic [DIV_W-1:0]   rem;
  logic [PROD_W-1:0]  target;
  logic [PROD_W-1:0]  gapCnt;
  logic [DIV_W:0]     remShift;
  logic [PROD_W:0]    cntPlus;

  assign remShift = {rem, quo[PROD_W-1]};
  assign cntPlus  = {1'b0, gapCnt} + 1'b1;

  // multiplier: shift-add over the multiplier bits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mulR   <= '0;
      divR   <= DIV_W'(1);
      addend <= '0;
      acc    <= '0;
    end else if (strb.load) begin
      mulR   <= stretchMul;
      divR   <= {1'b0, stretchDiv} + 1'b1;
      addend <= {{FIELD_W{1'b0}}, frameLen};
      acc    <= '0;
    end else if (strb.mulStep) begin
      if (mulR[0]) acc <= acc + addend;
      addend <= addend << 1;
      mulR   <= mulR >> 1;
    end
  end

  // restoring divider, quotient bits shift into the dividend register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      quo <= '0;
      rem <= '0;
    end else if (strb.divInit) begin
      quo <= acc;
      rem <= '0;
    end else if (strb.divStep) begin
      if (remShift >= {1'b0, divR}) begin
        rem <= DIV_W'(remShift - {1'b0, divR});
        quo <= {quo[PROD_W-2:0], 1'b1};
      end else begin
        rem <= remShift[DIV_W-1:0];
        quo <= {quo[PROD_W-2:0], 1'b0};
      end
    end
  end

  // gap target with floor
  always_ff @(posedge clk) begin
    if (!rstN) begin
      target <= MIN_V;
    end else if (strb.load) begin
      target <= MIN_V;
    end else if (strb.setTarget) begin
      target <= (quo < MIN_V) ? MIN_V : quo;
    end
  end

  // saturating bit-time counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strb.load) begin
      gapCnt <= '0;
    end else if (strb.cntRun && bitTick && gapCnt != CNT_MAX) begin
      gapCnt <= cntPlus[PROD_W-1:0];
    end
  end

  assign reachNow  = (gapCnt >= target);
  assign reachNext = bitTick && (cntPlus >= {1'b0, target});

  assert_target_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    target >= MIN_V)
    else $error("gap target below minimum");

  assert_cfg_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(divR))
    else $error("divisor changed without frame end");

endmodule

// File: rtl/ipg_timer_ctrl.sv
module ipg_timer_ctrl
  import ipg_timer_pkg::*;
#(
  parameter int MUL_W  = 8,
  parameter int PROD_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameEnd,
  input  logic        stretchEn,
  input  logic        reachNow,
  input  logic        reachNext,
  output gapStrobes_t strb,
  output logic        txReady
);

  localparam int STEP_W = $clog2(PROD_W + 1);
  localparam logic [STEP_W-1:0] MUL_LAST = STEP_W'(MUL_W - 1);
  localparam logic [STEP_W-1:0] DIV_LAST = STEP_W'(PROD_W - 1);
  localparam int COMP_LIMIT = MUL_W + PROD_W + 2;
  localparam int CC_W = $clog2(COMP_LIMIT + 2);

  gapState_t state, stateNext;
  logic [STEP_W-1:0] stepCnt, stepNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    stepNext  = stepCnt;
    if (frameEnd) begin
      strb.load = 1'b1;
      stateNext = stretchEn ? ST_MUL : ST_HOLD;
      stepNext  = '0;
    end else begin
      strb.cntRun = (state != ST_READY);
      case (state)
        ST_MUL: begin
          strb.mulStep = 1'b1;
          if (stepCnt == MUL_LAST) begin
            stateNext = ST_DINIT;
            stepNext  = '0;
          end else begin
            stepNext = stepCnt + 1'b1;
          end
        end
        ST_DINIT: begin
          strb.divInit = 1'b1;
          stateNext    = ST_DIV;
        end
        ST_DIV: begin
          strb.divStep = 1'b1;
          if (stepCnt == DIV_LAST) begin
            stateNext = ST_FIN;
            stepNext  = '0;
          end else begin
            stepNext = stepCnt + 1'b1;
          end
        end
        ST_FIN: begin
          strb.setTarget = 1'b1;
          stateNext      = ST_HOLD;
        end
        ST_HOLD: begin
          if (reachNow || reachNext) stateNext = ST_READY;
        end
        default: stateNext = ST_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_READY;
      stepCnt <= '0;
    end else begin
      state   <= stateNext;
      stepCnt <= stepNext;
    end
  end

  assign txReady = (state == ST_READY);

  // cycles spent computing since the last frame end
  logic [CC_W-1:0] compCycles;
  logic            computing;
  assign computing = (state == ST_MUL) || (state == ST_DINIT) ||
                     (state == ST_DIV) || (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rstN || frameEnd) compCycles <= '0;
    else if (computing && compCycles != {CC_W{1'b1}}) compCycles <= compCycles + 1'b1;
  end

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !txReady)
    else $error("ready still high after frame end");

  assert_ready_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !frameEnd) |=> txReady)
    else $error("ready fell without frame end");

  assert_compute_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    computing |-> compCycles <= CC_W'(COMP_LIMIT))
    else $error("computation exceeded its cycle bound");

endmodule

// File: rtl/ipg_timer.sv
module ipg_timer
  import ipg_timer_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int FIELD_W = 8,
  parameter int MIN_GAP = 96
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameEnd,
  input  logic [LEN_W-1:0]   frameLen,
  input  logic               stretchEn,
  input  logic [FIELD_W-1:0] stretchMul,
  input  logic [FIELD_W-1:0] stretchDiv,
  input  logic               bitTick,
  output logic               txReady
);

  localparam int PROD_W = LEN_W + FIELD_W;

  gapStrobes_t strb;
  logic reachNow, reachNext;

  ipg_timer_ctrl #(
    .MUL_W (FIELD_W),
    .PROD_W(PROD_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameEnd (frameEnd),
    .stretchEn(stretchEn),
    .reachNow (reachNow),
    .reachNext(reachNext),
    .strb     (strb),
    .txReady  (txReady)
  );

  ipg_timer_dp #(
    .LEN_W  (LEN_W),
    .FIELD_W(FIELD_W),
    .MIN_GAP(MIN_GAP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .frameLen  (frameLen),
    .stretchMul(stretchMul),
    .stretchDiv(stretchDiv),
    .bitTick   (bitTick),
    .reachNow  (reachNow),
    .reachNext (reachNext)
  );

endmodule

// File: tb/ipg_timer_tb.sv
module ipg_timer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameEnd = 1'b0;
  logic [15:0] frameLen = '0;
  logic        stretchEn = 1'b0;
  logic [7:0]  stretchMul = '0;
  logic [7:0]  stretchDiv = '0;
  logic        bitTick = 1'b0;
  logic        txReady;

  int checks = 0;
  int failures = 0;
  int expQ[$];
  string tagQ[$];
  bit measuring = 0;
  int tickCount = 0;

  always #5 clk = ~clk;

  ipg_timer u_dut (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .frameLen(frameLen),
    .stretchEn(stretchEn), .stretchMul(stretchMul), .stretchDiv(stretchDiv),
    .bitTick(bitTick), .txReady(txReady)
  );

  function automatic int expGap(int len, bit en, int mul, int dv);
    longint q;
    if (!en) return 96;
    q = (longint'(len) * mul) / (dv + 1);
    return (q < 96) ? 96 : int'(q);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: counts ticks from each frame end and compares at ready rise
  always @(posedge clk) begin
    if (rstN) begin
      if (frameEnd) begin
        measuring = 1;
        tickCount = 0;
      end else if (measuring && bitTick) begin
        tickCount++;
      end
    end
  end

  always @(negedge clk) begin
    if (measuring && txReady) begin
      measuring = 0;
      if (expQ.size() == 0) begin
        check(0, "scoreboard-empty", tickCount, -1);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(tickCount == e, t, tickCount, e);
      end
    end
  end

  task automatic pulseEnd(int len, bit en, int mul, int dv);
    @(negedge clk);
    frameLen = 16'(len); stretchEn = en;
    stretchMul = 8'(mul); stretchDiv = 8'(dv);
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    check(txReady == 1'b0, "R2 ready drop", int'(txReady), 0);
  endtask

  task automatic runTicks(int spacing, int maxCycles);
    int phase = 0;
    for (int i = 0; i < maxCycles; i++) begin
      if (txReady) break;
      bitTick = (phase == 0);
      phase = (phase + 1) % spacing;
      @(negedge clk);
    end
    bitTick = 1'b0;
  endtask

  task automatic sendFrame(int len, bit en, int mul, int dv, int spacing, string tag);
    expQ.push_back(expGap(len, en, mul, dv));
    tagQ.push_back(tag);
    pulseEnd(len, en, mul, dv);
    runTicks(spacing, 40000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(txReady == 1'b1, "R1 reset ready", int'(txReady), 1);

    // R1 / R9: idle ticks keep ready high
    for (int i = 0; i < 20; i++) begin bitTick = 1'b1; @(negedge clk); end
    bitTick = 1'b0;
    check(txReady == 1'b1, "R1 idle ticks", int'(txReady), 1);

    sendFrame(1000, 0, 3, 9, 1, "R3 fixed gap dense");
    sendFrame(1000, 0, 3, 9, 3, "R3 fixed gap sparse");
    sendFrame(1000, 1, 3, 9, 2, "R4 stretch 300");
    sendFrame(1500, 1, 200, 255, 1, "R4 stretch 1171");
    sendFrame(200, 1, 1, 0, 1, "R4 div zero");
    sendFrame(4000, 1, 255, 127, 1, "R4 large product");
    sendFrame(97, 1, 1, 0, 1, "R8 tick every cycle");
    sendFrame(500, 1, 1, 99, 1, "R5 floor small");
    sendFrame(1500, 1, 0, 5, 3, "R5 zero multiplier");

    // R6: configuration changed mid-gap is ignored
    expQ.push_back(expGap(1000, 1, 3, 9));
    tagQ.push_back("R6 config held");
    pulseEnd(1000, 1, 3, 9);
    for (int i = 0; i < 10; i++) begin bitTick = 1'b1; @(negedge clk); end
    stretchEn = 1'b0; stretchMul = 8'd255; stretchDiv = 8'd0; frameLen = 16'd9;
    runTicks(1, 40000);

    // R9: ticks while ready are not stored
    for (int i = 0; i < 200; i++) begin bitTick = 1'b1; @(negedge clk); end
    bitTick = 1'b0;
    check(txReady == 1'b1, "R9 ready held", int'(txReady), 1);
    sendFrame(1000, 0, 0, 0, 1, "R9 full gap after idle ticks");

    // R7: restart during gap
    pulseEnd(1000, 1, 3, 9);
    for (int i = 0; i < 40; i++) begin bitTick = 1'b1; @(negedge clk); end
    bitTick = 1'b0;
    check(txReady == 1'b0, "R7 still gapping", int'(txReady), 0);
    sendFrame(300, 0, 3, 9, 1, "R7 restart");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule